// File: doc/BRIEF.md
# Privilege Mode Trap Controller

This block keeps the privilege level of a simple in-order core and performs every transfer of control between user and kernel mode. Each cycle it looks at the requests from the core: a synchronous exception carrying its own cause code, a system call, a decode flag marking a privileged instruction, an external interrupt line and a return-from-trap strobe, together with the PC of the instruction concerned. From these it decides whether to trap, to return or to do nothing.

A trap is one atomic step. In a single clock edge the block stores the cause and the PC, enters kernel mode, saves and then clears the interrupt enable, and sends fetch to the one kernel entry address. Kernel software reads the cause register, masks it with 0x7C and uses the result as a word-aligned index into its handler table. A return from the kernel sends fetch back to the saved PC, drops to user mode and restores the interrupt enable that was in force before the trap. A privileged instruction or a return strobe seen in user mode never executes; it becomes a reserved-instruction trap.

Top module: `priv_trap_ctrl`

## Requirements
- R1: During and after a synchronous reset (`rst` high), `kmode` is 1, `ie_q` is 0, `redir_valid` is 0, `redir_pc` equals BOOT_ADDR (default 0x100), and `cause_q` and `epc_q` are 0. The interrupt enable saved for the first return is 1.
- R2: `kmode` is the mode bit: 1 means kernel mode and 0 means user mode. It stays at its value until a trap sets it to 1 or a return clears it to 0.
- R3: When `priv_instr` is high in user mode and no `exc_req` is raised, the block traps with cause code 10. When `priv_instr` is high in kernel mode, it has no effect and `redir_valid` stays 0.
- R4: A trap is visible in the cycle after the request edge. In that cycle `redir_valid` is 1 for exactly one cycle, `redir_pc` equals ENTRY_ADDR (default 0x80), `kmode` is 1, `ie_q` is 0, `epc_q` holds the `pc_in` sampled at the request, and `cause_q` holds the cause code in bits 6:2 with all other bits 0.
- R5: The cause codes are 0 for an external interrupt, 8 for a system call (`sys_req`), 10 for a reserved or privileged instruction, and the value of `exc_code` for `exc_req`.
- R6: When `trap_ret` is high in kernel mode and no synchronous trap is raised, the next cycle shows `redir_valid` 1, `redir_pc` equal to `epc_q`, `kmode` 0, and `ie_q` equal to the value it had just before the last trap.
- R7: An external interrupt (`irq` high) traps only when `ie_q` is 1. The saved PC is the `pc_in` of that cycle. When `ie_q` is 0, `irq` has no effect.
- R8: When several requests arrive in the same cycle, the block serves them in this order: `exc_req`, then the user-mode reserved-instruction cases, then `sys_req`, then the kernel return, then the interrupt.
- R9: When `trap_ret` is high in user mode, the block does not return. It traps with cause code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Cause code that goes with exc_req |
| sys_req | input | 1 | System-call request |
| priv_instr | input | 1 | Decoded instruction is privileged |
| irq | input | 1 | External interrupt line |
| pc_in | input | XLEN | PC of the current instruction |
| trap_ret | input | 1 | Return-from-trap strobe |
| redir_pc | output | XLEN | Fetch redirect target |
| redir_valid | output | 1 | One-cycle redirect pulse |
| kmode | output | 1 | Mode bit, 1 = kernel |
| ie_q | output | 1 | Interrupt enable |
| cause_q | output | XLEN | Cause register, code in bits 6:2 |
| epc_q | output | XLEN | Saved exception PC |

## Verification
A wrong mode bit shows on `kmode` one cycle after the request. It then changes how every later privileged instruction and return is handled, so a stuck or inverted mode produces a missing or extra `redir_valid` within a few requests. A lost saved interrupt enable shows on `ie_q` right after the next return, and it shows again when a later interrupt is either wrongly taken or wrongly ignored. A wrong priority or a wrong cause field shows on `cause_q` in the cycle after a request that raised several lines at once. A wrong saved PC shows on `redir_pc` at the next return.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_INT = 5'd0;
  localparam logic [CODE_W-1:0] CODE_SYS = 5'd8;
  localparam logic [CODE_W-1:0] CODE_RI  = 5'd10;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TRAP = 2'd1,
    ACT_RET  = 2'd2
  } trap_act_e;

endpackage

// File: rtl/priv_trap_arbiter.sv
module priv_trap_arbiter
  import priv_trap_pkg::*;
(
  input  logic              mode,
  input  logic              ie,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              sys_req,
  input  logic              priv_instr,
  input  logic              irq,
  input  logic              trap_ret,
  output trap_act_e         act,
  output logic [CODE_W-1:0] code
);

  logic user_ri;
  assign user_ri = !mode && (priv_instr || trap_ret);

  // Fixed priority: synchronous causes first, interrupt last.
  always_comb begin
    act  = ACT_NONE;
    code = '0;
    if (exc_req) begin
      act  = ACT_TRAP;
      code = exc_code;
    end else if (user_ri) begin
      act  = ACT_TRAP;
      code = CODE_RI;
    end else if (sys_req) begin
      act  = ACT_TRAP;
      code = CODE_SYS;
    end else if (mode && trap_ret) begin
      act  = ACT_RET;
    end else if (irq && ie) begin
      act  = ACT_TRAP;
      code = CODE_INT;
    end
  end

endmodule

// File: rtl/priv_trap_status.sv
module priv_trap_status
  import priv_trap_pkg::*;
#(
  parameter logic PIE_RESET = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  trap_act_e act,
  output logic      mode,
  output logic      ie
);

  logic pie;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= 1'b1;
      ie   <= 1'b0;
      pie  <= PIE_RESET;
    end else begin
      case (act)
        ACT_TRAP: begin
          pie  <= ie;
          ie   <= 1'b0;
          mode <= 1'b1;
        end
        ACT_RET: begin
          ie   <= pie;
          mode <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/priv_trap_regs.sv
module priv_trap_regs
  import priv_trap_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  trap_act_e         act,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   pc_in,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   epc
);

  localparam int CAUSE_MSB = CAUSE_LSB + CODE_W - 1;

  logic [CODE_W-1:0] code_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_r <= '0;
      epc    <= '0;
    end else if (act == ACT_TRAP) begin
      code_r <= code;
      epc    <= pc_in;
    end
  end

  // Only the code field is stored; the other bits read as zero.
  for (genvar b = 0; b < XLEN; b++) begin : g_cause
    if (b >= CAUSE_LSB && b <= CAUSE_MSB) begin : g_fld
      assign cause[b] = code_r[b-CAUSE_LSB];
    end else begin : g_zero
      assign cause[b] = 1'b0;
    end
  end

endmodule

// File: rtl/priv_trap_redirect.sv
module priv_trap_redirect
  import priv_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] BOOT_ADDR  = 32'h0000_0100,
  parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  trap_act_e       act,
  input  logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] rpc,
  output logic            rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rpc    <= BOOT_ADDR;
      rvalid <= 1'b0;
    end else begin
      rvalid <= (act != ACT_NONE);
      case (act)
        ACT_TRAP: rpc <= ENTRY_ADDR;
        ACT_RET:  rpc <= epc;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              CAUSE_LSB  = 2,
  parameter logic [XLEN-1:0] BOOT_ADDR  = 32'h0000_0100,
  parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0080,
  parameter logic            PIE_RESET  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              sys_req,
  input  logic              priv_instr,
  input  logic              irq,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              trap_ret,
  output logic [XLEN-1:0]   redir_pc,
  output logic              redir_valid,
  output logic              kmode,
  output logic              ie_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q
);

  trap_act_e         act;
  logic [CODE_W-1:0] code;

  priv_trap_arbiter u_arb (
    .mode       (kmode),
    .ie         (ie_q),
    .exc_req    (exc_req),
    .exc_code   (exc_code),
    .sys_req    (sys_req),
    .priv_instr (priv_instr),
    .irq        (irq),
    .trap_ret   (trap_ret),
    .act        (act),
    .code       (code)
  );

  priv_trap_status #(.PIE_RESET(PIE_RESET)) u_status (
    .clk  (clk),
    .rst  (rst),
    .act  (act),
    .mode (kmode),
    .ie   (ie_q)
  );

  priv_trap_regs #(.XLEN(XLEN), .CAUSE_LSB(CAUSE_LSB)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .code  (code),
    .pc_in (pc_in),
    .cause (cause_q),
    .epc   (epc_q)
  );

  priv_trap_redirect #(
    .XLEN(XLEN), .BOOT_ADDR(BOOT_ADDR), .ENTRY_ADDR(ENTRY_ADDR)
  ) u_redir (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .epc    (epc_q),
    .rpc    (redir_pc),
    .rvalid (redir_valid)
  );

endmodule

// File: rtl/priv_trap_ctrl_chk.sv
module priv_trap_ctrl_chk
  import priv_trap_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              CAUSE_LSB  = 2,
  parameter logic [XLEN-1:0] BOOT_ADDR  = 32'h0000_0100,
  parameter logic [XLEN-1:0] ENTRY_ADDR = 32'h0000_0080
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_req,
  input logic [CODE_W-1:0] exc_code,
  input logic              sys_req,
  input logic              priv_instr,
  input logic              irq,
  input logic [XLEN-1:0]   pc_in,
  input logic              trap_ret,
  input logic [XLEN-1:0]   redir_pc,
  input logic              redir_valid,
  input logic              kmode,
  input logic              ie_q,
  input logic [XLEN-1:0]   cause_q,
  input logic [XLEN-1:0]   epc_q
);

  localparam int CAUSE_MSB = CAUSE_LSB + CODE_W - 1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (kmode && !ie_q && !redir_valid && redir_pc == BOOT_ADDR));

  // R4
  trap_masks_ie_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && kmode) |-> !ie_q);

  // R4
  trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && kmode) |-> (redir_pc == ENTRY_ADDR));

  // R3
  user_priv_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (!kmode && priv_instr && !exc_req) |=>
      (redir_valid && kmode && cause_q[CAUSE_MSB:CAUSE_LSB] == CODE_RI));

  // R6
  kernel_return_chk: assert property (@(posedge clk) disable iff (rst)
    (kmode && trap_ret && !exc_req && !sys_req) |=>
      (redir_valid && !kmode && redir_pc == $past(epc_q)));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && irq && !exc_req && !sys_req && !priv_instr && !trap_ret) |=> !redir_valid);

  // R8
  exc_priority_chk: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (cause_q[CAUSE_MSB:CAUSE_LSB] == $past(exc_code) && epc_q == $past(pc_in)));

  // R9
  user_ret_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (!kmode && trap_ret && !exc_req) |=> (kmode && cause_q[CAUSE_MSB:CAUSE_LSB] == CODE_RI));

endmodule

bind priv_trap_ctrl priv_trap_ctrl_chk #(
  .XLEN(XLEN), .CAUSE_LSB(CAUSE_LSB), .BOOT_ADDR(BOOT_ADDR), .ENTRY_ADDR(ENTRY_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .sys_req(sys_req),
  .priv_instr(priv_instr), .irq(irq), .pc_in(pc_in), .trap_ret(trap_ret),
  .redir_pc(redir_pc), .redir_valid(redir_valid), .kmode(kmode), .ie_q(ie_q),
  .cause_q(cause_q), .epc_q(epc_q)
);

// File: tb/priv_trap_ctrl_tb_top.sv
module priv_trap_ctrl_tb_top;

  localparam logic [31:0] BOOT  = 32'h0000_0100;
  localparam logic [31:0] ENTRY = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 0, sys_req = 0, priv_instr = 0, irq = 0, trap_ret = 0;
  logic [4:0]  exc_code = 0;
  logic [31:0] pc_in = 0;
  logic [31:0] redir_pc, cause_q, epc_q;
  logic        redir_valid, kmode, ie_q;

  int checks = 0;
  int errors = 0;

  // expected state derived from the requirements
  logic        m_mode, m_ie, m_pie, m_rv;
  logic [31:0] m_rpc, m_cause, m_epc;
  string       m_tag;

  always #10 clk = ~clk;

  priv_trap_ctrl dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .sys_req(sys_req),
    .priv_instr(priv_instr), .irq(irq), .pc_in(pc_in), .trap_ret(trap_ret),
    .redir_pc(redir_pc), .redir_valid(redir_valid), .kmode(kmode), .ie_q(ie_q),
    .cause_q(cause_q), .epc_q(epc_q)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 1; m_ie = 0; m_pie = 1; m_rv = 0;
    m_rpc = BOOT; m_cause = 0; m_epc = 0;
  endtask

  function automatic logic [31:0] cause_of(logic [4:0] c);
    return {25'd0, c, 2'b00};
  endfunction

  task automatic model_step();
    logic take;
    logic [4:0] c;
    take = 0; c = 0;
    m_rv = 0;
    if (exc_req) begin take = 1; c = exc_code; m_tag = "R8"; end
    else if (!m_mode && (priv_instr || trap_ret)) begin take = 1; c = 5'd10; m_tag = "R3"; end
    else if (sys_req) begin take = 1; c = 5'd8; m_tag = "R5"; end
    else if (m_mode && trap_ret) begin
      m_mode = 0; m_ie = m_pie; m_rpc = m_epc; m_rv = 1; m_tag = "R6";
    end else if (irq && m_ie) begin take = 1; c = 5'd0; m_tag = "R7"; end
    else m_tag = "R2";
    if (take) begin
      m_pie = m_ie; m_ie = 0; m_mode = 1; m_cause = cause_of(c);
      m_epc = pc_in; m_rpc = ENTRY; m_rv = 1;
    end
  endtask

  task automatic compare_all();
    chk({m_tag, " redir_valid"}, {31'd0, redir_valid}, {31'd0, m_rv});
    chk({m_tag, " redir_pc"}, redir_pc, m_rpc);
    chk({m_tag, " kmode"}, {31'd0, kmode}, {31'd0, m_mode});
    chk({m_tag, " ie"}, {31'd0, ie_q}, {31'd0, m_ie});
    chk({m_tag, " cause"}, cause_q, m_cause);
    chk({m_tag, " epc"}, epc_q, m_epc);
  endtask

  // Drive on the falling edge, sample mid-cycle after the rising edge.
  task automatic step(logic e, logic [4:0] ec, logic s, logic p, logic i,
                      logic r, logic [31:0] pc);
    @(negedge clk);
    exc_req = e; exc_code = ec; sys_req = s; priv_instr = p; irq = i;
    trap_ret = r; pc_in = pc;
    model_step();
    @(posedge clk);
    #5;
    compare_all();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #5;
    m_tag = "R1";
    compare_all();
    chk("R1 redir_pc boot", redir_pc, BOOT);
    chk("R1 kmode", {31'd0, kmode}, 32'd1);
    @(negedge clk);
    rst = 0;

    // R3: privileged instruction in kernel mode has no effect
    step(0, 0, 0, 1, 0, 0, 32'h40);
    chk("R3 kernel priv no redirect", {31'd0, redir_valid}, 32'd0);
    // R2, R6: first return drops to user, ie restored to 1
    step(0, 0, 0, 0, 0, 1, 32'h44);
    chk("R2 user after return", {31'd0, kmode}, 32'd0);
    chk("R6 ie restored", {31'd0, ie_q}, 32'd1);
    // R7, R4: interrupt taken with ie set
    step(0, 0, 0, 0, 1, 0, 32'h1000);
    chk("R7 irq cause", cause_q, 32'h0);
    chk("R7 irq epc", epc_q, 32'h1000);
    chk("R4 entry", redir_pc, ENTRY);
    step(0, 0, 0, 0, 0, 0, 32'h84);
    chk("R4 pulse one cycle", {31'd0, redir_valid}, 32'd0);
    step(0, 0, 0, 0, 0, 1, 32'h88);
    chk("R6 return pc", redir_pc, 32'h1000);
    // R5: system call
    step(0, 0, 1, 0, 0, 0, 32'h2000);
    chk("R5 sys cause", cause_q, 32'h20);
    step(0, 0, 0, 0, 0, 1, 32'h8c);
    // R3: user privileged instruction
    step(0, 0, 0, 1, 0, 0, 32'h3000);
    chk("R3 user priv cause", cause_q, 32'h28);
    step(0, 0, 0, 0, 0, 1, 32'h90);
    // R9: return strobe in user mode traps
    step(0, 0, 0, 0, 0, 1, 32'h4000);
    chk("R9 user ret cause", cause_q, 32'h28);
    chk("R9 kmode", {31'd0, kmode}, 32'd1);
    step(0, 0, 0, 0, 0, 1, 32'h94);
    // R8: exception wins over syscall and interrupt
    step(1, 5'd13, 1, 0, 1, 0, 32'h5000);
    chk("R8 priority cause", cause_q, 32'h34);
    // R7: interrupt masked in kernel
    step(0, 0, 0, 0, 1, 0, 32'h98);
    chk("R7 masked irq", {31'd0, redir_valid}, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      logic e, s, p, i, r;
      e = ($urandom_range(0, 15) == 0);
      s = ($urandom_range(0, 9) == 0);
      p = ($urandom_range(0, 7) == 0);
      i = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 3) == 0);
      step(e, 5'($urandom), s, p, i, r, {$urandom} & 32'hFFFF_FFFC);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule